// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Shoot-Through Guard

This block takes a single PWM command and produces two gate enables, one for the upper switch and one for the lower switch of a half bridge. The two enables are never active at the same time. A rising PWM command first removes the lower enable. The upper enable is granted only after a feedback flag reports that the lower gate has actually discharged. A falling PWM command removes the upper enable at once. The lower enable then waits for a second feedback flag, which reports that the switch node has fallen. If that flag does not arrive within a programmable number of clock cycles, the lower enable is forced on.

Once granted, the lower enable is held until the next PWM rise, so a ringing switch node cannot chatter it. A separate permit input can veto the lower switch at any moment. All four inputs are asynchronous to the clock and each passes through a two-flop synchronizer. Any change at an input therefore reaches the state register on the third rising clock edge after it. The enables are decoded from the state register, and the lower enable is also gated by the synchronized permit.

Top module: `half_bridge_seq`

## Requirements
- R1: `hi_drv` and `lo_drv` are never 1 in the same cycle.
- R2: During and after reset, `hi_drv` and `lo_drv` are 0 and `seq_state` is 0 (idle) until PWM is seen high.
- R3: When synchronized PWM goes high, `lo_drv` is 0 from the next edge on and `seq_state` becomes 1. `hi_drv` stays 0 until the synchronized `lo_off_in` is 1, and then `seq_state` becomes 2 and `hi_drv` becomes 1.
- R4: When synchronized PWM goes low, `hi_drv` drops on the next edge and `seq_state` becomes 3 (waiting for the lower switch).
- R5: In state 3, with the permit high, a high synchronized `sw_low_in` moves the block to state 4 and sets `lo_drv` to 1.
- R6: In state 4, `lo_drv` stays 1 whatever `sw_low_in` does. It is cleared only by a PWM rise, which moves the block to state 1, or by the permit.
- R7: If `sw_low_in` stays low, `lo_drv` rises exactly TIMEOUT clock cycles after `hi_drv` falls.
- R8: While `lo_permit_in` is low, neither the flag nor the timeout sets `lo_drv`. If the permit returns while the flag is set or the timeout has expired, the block moves to state 4.
- R9: If the permit goes low in state 4, `lo_drv` drops two edges after the change and the block moves to state 0. The lower switch then stays off until the next PWM cycle, even if the permit returns.
- R10: With the permit low at a PWM rise, `hi_drv` follows the normal R3/R4 sequence and `lo_drv` stays 0.
- R11: `seq_state` encodes the states as 0 idle, 1 lower-off wait, 2 upper on, 3 switch-node wait, 4 lower on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | PWM command, asynchronous |
| lo_off_in | input | 1 | 1 when the lower gate has fallen below its off level |
| sw_low_in | input | 1 | 1 when the switch node has fallen below its threshold |
| lo_permit_in | input | 1 | Lower-switch permit; 0 forces the lower enable off |
| hi_drv | output | 1 | Upper gate enable |
| lo_drv | output | 1 | Lower gate enable |
| seq_state | output | 3 | Sequencer state code (R11) |

## Verification
Two situations are the hardest to reach from the ports. The first is the forced lower turn-on: it needs a switch-node flag that stays low for the whole timeout. The second is the combination of the permit veto with a flag or timeout that has already expired. Directed sequences hold `sw_low_in` low and count cycles from the upper enable's fall to the lower enable's rise. They then withdraw the permit across a full timeout, raise the flag, and return the permit. Random phases follow, with rare PWM and permit toggles and fast flag toggles, checked cycle by cycle against a bench model that includes the synchronizer latency.

// File: rtl/half_bridge_seq.sv
module half_bridge_seq #(
  parameter int TIMEOUT = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_in,
  input  logic       lo_off_in,
  input  logic       sw_low_in,
  input  logic       lo_permit_in,
  output logic       hi_drv,
  output logic       lo_drv,
  output logic [2:0] seq_state
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  typedef enum logic [2:0] {
    IDLE    = 3'd0,
    LO_DROP = 3'd1,
    HI_ON   = 3'd2,
    SW_WAIT = 3'd3,
    LO_ON   = 3'd4
  } st_t;

  st_t state, nxt;
  logic [3:0] sy1, sy2;
  logic [CW-1:0] cnt;
  logic pwm_s, lo_off_s, sw_low_s, permit_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= {pwm_in, lo_off_in, sw_low_in, lo_permit_in};
      sy2 <= sy1;
    end

  assign {pwm_s, lo_off_s, sw_low_s, permit_s} = sy2;

  always_comb begin
    nxt = state;
    case (state)
      IDLE:    if (pwm_s) nxt = LO_DROP;
      LO_DROP: if (!pwm_s) nxt = SW_WAIT;
               else if (lo_off_s) nxt = HI_ON;
      HI_ON:   if (!pwm_s) nxt = SW_WAIT;
      SW_WAIT: if (pwm_s) nxt = LO_DROP;
               else if (permit_s && (sw_low_s || cnt == LAST)) nxt = LO_ON;
      LO_ON:   if (pwm_s) nxt = LO_DROP;
               else if (!permit_s) nxt = IDLE;
      default: nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (state != SW_WAIT) cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

  assign hi_drv    = (state == HI_ON);
  assign lo_drv    = (state == LO_ON) && permit_s;
  assign seq_state = state;

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_drv && lo_drv));

  // R3
  hi_after_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_drv) |-> $past(lo_off_s) && $past(pwm_s));

  // R4
  hi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_drv && !pwm_s) |=> !hi_drv);

  // R6
  lo_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_drv && !pwm_s && permit_s) |=> (state == LO_ON));

  // R7
  lo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lo_drv) && $past(state) == SW_WAIT) |->
      ($past(sw_low_s) || $past(cnt) == LAST) && $past(permit_s));
endmodule

// File: tb/half_bridge_seq_test.sv
`timescale 1ns/1ps
module half_bridge_seq_test;
  localparam int TO = 25;
  logic clk = 0, rst_n = 0;
  logic pwm = 0, lo_off = 0, sw_low = 0, permit = 1;
  logic hi, lo;
  logic [2:0] st;
  int checks = 0, fails = 0;
  bit done = 0, cmp_on = 0;

  half_bridge_seq #(.TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .lo_off_in(lo_off),
    .sw_low_in(sw_low), .lo_permit_in(permit),
    .hi_drv(hi), .lo_drv(lo), .seq_state(st));

  always #2.5 clk = ~clk;

  // bench model built from the requirements
  logic [3:0] m1, m2;
  logic [2:0] ms;
  int mc;
  function automatic logic [2:0] next_st(logic [2:0] s, logic [3:0] in, int c);
    logic p = in[3], lf = in[2], sl = in[1], pm = in[0];
    case (s)
      3'd0: return p ? 3'd1 : 3'd0;
      3'd1: return !p ? 3'd3 : (lf ? 3'd2 : 3'd1);
      3'd2: return p ? 3'd2 : 3'd3;
      3'd3: return p ? 3'd1 : ((pm && (sl || c >= TO - 1)) ? 3'd4 : 3'd3);
      3'd4: return p ? 3'd1 : (pm ? 3'd4 : 3'd0);
      default: return 3'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m1 <= '0; m2 <= '0; ms <= '0; mc <= 0;
    end else begin
      m1 <= {pwm, lo_off, sw_low, permit};
      m2 <= m1;
      ms <= next_st(ms, m2, mc);
      mc <= (ms != 3'd3) ? 0 : ((mc < TO - 1) ? mc + 1 : mc);
    end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk)
    if (cmp_on) begin
      chk("R1 overlap", {7'd0, hi & lo}, 8'd0);
      chk("R11 model state", {5'd0, st}, {5'd0, ms});
      chk("R3 model hi", {7'd0, hi}, {7'd0, ms == 3'd2});
      chk("R9 model lo", {7'd0, lo}, {7'd0, ms == 3'd4 && m2[0]});
    end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h1F2E));
    step(3);
    chk("R2 reset hi", {7'd0, hi}, 8'd0);
    chk("R2 reset lo", {7'd0, lo}, 8'd0);
    chk("R2 reset state", {5'd0, st}, 8'd0);
    rst_n = 1;
    step(5);
    chk("R2 idle state", {5'd0, st}, 8'd0);
    // normal cycle
    pwm = 1; step(3);
    chk("R3 lower-off wait state", {5'd0, st}, 8'd1);
    step(5);
    chk("R3 hi held without feedback", {7'd0, hi}, 8'd0);
    lo_off = 1; step(3);
    chk("R3 hi on", {7'd0, hi}, 8'd1);
    chk("R11 state 2", {5'd0, st}, 8'd2);
    pwm = 0; step(3);
    chk("R4 hi off", {7'd0, hi}, 8'd0);
    chk("R4 state 3", {5'd0, st}, 8'd3);
    sw_low = 1; step(3);
    chk("R5 lo on", {7'd0, lo}, 8'd1);
    chk("R11 state 4", {5'd0, st}, 8'd4);
    for (int i = 0; i < 8; i++) begin
      sw_low = ~sw_low; step(1);
      chk("R6 lo latched", {7'd0, lo}, 8'd1);
    end
    sw_low = 0;
    pwm = 1; step(3);
    chk("R6 lo cleared by pwm rise", {7'd0, lo}, 8'd0);
    chk("R6 state 1", {5'd0, st}, 8'd1);
    step(3);
    // timeout
    pwm = 0; step(3);
    chk("R7 hi fell", {7'd0, hi}, 8'd0);
    n = 0;
    while (!lo && n < 100) begin step(1); n++; end
    chk("R7 timeout cycles", 8'(n), 8'(TO));
    // permit veto during wait
    pwm = 1; step(6);
    chk("R8 hi on again", {7'd0, hi}, 8'd1);
    permit = 0; pwm = 0; step(TO + 8);
    chk("R8 no forced lo", {7'd0, lo}, 8'd0);
    chk("R8 state 3", {5'd0, st}, 8'd3);
    sw_low = 1; step(5);
    chk("R8 flag ignored", {7'd0, lo}, 8'd0);
    permit = 1; step(3);
    chk("R8 lo on after permit", {7'd0, lo}, 8'd1);
    // permit veto while on
    permit = 0; step(2);
    chk("R9 lo off", {7'd0, lo}, 8'd0);
    chk("R9 hi off", {7'd0, hi}, 8'd0);
    step(1);
    chk("R9 state idle", {5'd0, st}, 8'd0);
    permit = 1; step(6);
    chk("R9 lo stays off", {7'd0, lo}, 8'd0);
    // permit low at pwm rise
    permit = 0; sw_low = 0; step(3);
    pwm = 1; step(4);
    chk("R10 hi on", {7'd0, hi}, 8'd1);
    chk("R10 lo off", {7'd0, lo}, 8'd0);
    pwm = 0; sw_low = 1; step(TO + 6);
    chk("R10 hi off", {7'd0, hi}, 8'd0);
    chk("R10 lo stays off", {7'd0, lo}, 8'd0);
    permit = 1; sw_low = 0; pwm = 0; step(4);
    // random phase
    cmp_on = 1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk); #1;
      if ($urandom_range(39) == 0) pwm = ~pwm;
      if ($urandom_range(3) == 0) lo_off = ~lo_off;
      if ($urandom_range(5) == 0) sw_low = ~sw_low;
      if ($urandom_range(59) == 0) permit = ~permit;
      if (i == 3000) sw_low = 0;
      if (i > 3000 && i < 4500) sw_low = 0;
    end
    cmp_on = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule